// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Logger

This block sits on the path between a memory array and its requesters. It guards each 16-bit data word with six check bits. On the write side it produces the check bits that are stored next to the word. On the read side it recomputes the check bits from the returned data and XORs them with the stored ones to form a six-bit syndrome. The syndrome identifies which stored bit flipped. A single flipped bit, in either the data or the check field, is repaired before the word leaves the block. Any pattern the code cannot map to a single position is reported as a multi-bit fault, and the word is passed on unchanged.

Every detected fault is recorded for software. The block holds the syndrome and the 20-bit address of the failing read and raises an interrupt request. A multi-bit fault also pulses a bus-error signal alongside the returned word and raises a non-maskable request. The record keeps its first contents until software clears it. A 16-bit diagnostic register lets software switch correction off and pick one of four modes. Two of these modes corrupt the stored check bits on purpose, and one silences reporting, so that test code can inject faults and exercise the whole path.

Top module: `ecc_err_logger`

## Requirements
- R1: In mode 0, `wrCheck` equals the code of `wrData`. Check bit c is the XOR of every data bit i whose column has bit c set. The columns for data bits 0 to 15 are 0Eh, 0Bh, 07h, 0Dh, 13h, 15h, 16h, 19h, 1Ah, 1Ch, 23h, 25h, 26h, 29h, 2Ah and 2Ch. Check bit k has column 1<<k.
- R2: A read sampled with `rdValid` is answered one clock later: `outValid` is high for one cycle and carries `outData`. When the syndrome is zero, `outData` equals `rdData`, `busErr` stays low and nothing is logged.
- R3: When the syndrome equals the column of a data bit, that bit is inverted in `outData` (correction enabled) and the fault is logged as single.
- R4: When the syndrome has exactly one bit k set, the fault is logged as single and `outData` equals `rdData`.
- R5: Any other nonzero syndrome is a multi-bit fault. `outData` equals `rdData`, and `busErr` is high in the same cycle as `outValid`.
- R6: A logged fault makes `irq` high. Register 1 holds the syndrome and register 2 holds address bits 15:0. Register 0 (status) holds address bits 19:16 in bits 3:0, the single flag in bit 4 and the multi flag in bit 5. A multi fault also makes `nmi` high.
- R7: While a fault is held, later faults change nothing. Any write to register 0 zeroes the record and drops `irq` and `nmi`. A fault read in the same cycle as that write is captured.
- R8: Diagnostic register 3 resets to 0004h. Bits 1:0 select the mode, bit 2 enables correction and bits 13:8 are a check pattern. All 16 bits read back as written.
- R9: With bit 2 cleared, `outData` equals `rdData` for every syndrome, and faults are still logged.
- R10: In mode 1, `wrCheck` equals the pattern field.
- R11: In mode 3, `wrCheck` equals the code of `wrData` XOR the pattern field.
- R12: In mode 2, faults are neither logged nor signalled on `busErr`. Correction still follows bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 16 | Word being written to memory |
| wrCheck | output | 6 | Check bits to store with the word |
| rdValid | input | 1 | A read word is present this cycle |
| rdAddr | input | 20 | Address of the read |
| rdData | input | 16 | Data bits as read from memory |
| rdCheck | input | 6 | Check bits as read from memory |
| outValid | output | 1 | Returned word valid |
| outData | output | 16 | Returned (possibly corrected) word |
| busErr | output | 1 | Multi-bit fault on the returned word |
| irq | output | 1 | A fault record is held |
| nmi | output | 1 | The held record is a multi-bit fault |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |

## Verification
A wrong column table shows up at once. It gives the wrong `wrCheck` for the written word and a wrong syndrome in register 1 after the next injected fault. It also either leaves the flipped bit in `outData` or flips the wrong one, one clock after the read. A record that is overwritten or not held becomes visible on the first register read after a second fault. A missing clear shows up as `irq` still high on the cycle after the status write. Misclassifying a fault appears as a wrong `busErr` beside that same returned word, and as a wrong flag in the status register.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam int REG_W  = 16;
  localparam int REG_AW = 2;

  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef chk_t colTab_t [DATA_W];

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_SUBST  = 2'd1;
  localparam logic [1:0] MODE_QUIET  = 2'd2;
  localparam logic [1:0] MODE_FLIP   = 2'd3;

  localparam logic [REG_AW-1:0] REG_STATUS = 2'd0;
  localparam logic [REG_AW-1:0] REG_SYN    = 2'd1;
  localparam logic [REG_AW-1:0] REG_ADDRLO = 2'd2;
  localparam logic [REG_AW-1:0] REG_DIAG   = 2'd3;

  localparam int DIAG_MODE_LSB = 0;
  localparam int DIAG_CORR_BIT = 2;
  localparam int DIAG_PAT_LSB  = 8;
  localparam logic [REG_W-1:0] DIAG_RESET = 16'h0004;

  // Data bits 0 and 1 take fixed columns; the rest take the remaining
  // odd-weight codes of weight three or more in ascending order.
  function automatic colTab_t buildCols();
    colTab_t t;
    int n;
    for (int i = 0; i < DATA_W; i++) t[i] = '0;
    t[0] = chk_t'(6'h0E);
    t[1] = chk_t'(6'h0B);
    n = 2;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int v = 1; v < (1 << CHK_W); v++) begin
        if ($countones(v) == w && v != 'h0E && v != 'h0B && n < DATA_W) begin
          t[n] = chk_t'(v);
          n++;
        end
      end
    end
    return t;
  endfunction

  localparam colTab_t COLS = buildCols();

  function automatic chk_t genCheck(word_t d);
    chk_t r;
    r = '0;
    for (int c = 0; c < CHK_W; c++)
      for (int i = 0; i < DATA_W; i++)
        if (COLS[i][c]) r[c] = r[c] ^ d[i];
    return r;
  endfunction

  typedef struct packed {
    logic clrLatch;
    logic wrDiag;
    logic capture;
    logic capMulti;
    logic raiseBus;
  } ctl_t;
endpackage

// File: rtl/ecc_control.sv
module ecc_control
  import ecc_pkg::*;
(
  input  logic              rdValid,
  input  logic              errSingle,
  input  logic              errMulti,
  input  logic              latchBusy,
  input  logic [1:0]        diagMode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output ctl_t              ctl
);
  logic reportOk;

  always_comb begin
    reportOk     = rdValid && (diagMode != MODE_QUIET);
    ctl.clrLatch = regWrEn && (regAddr == REG_STATUS);
    ctl.wrDiag   = regWrEn && (regAddr == REG_DIAG);
    ctl.raiseBus = reportOk && errMulti;
    ctl.capture  = reportOk && (errSingle || errMulti) && (!latchBusy || ctl.clrLatch);
    ctl.capMulti = errMulti;
  end
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  ctl_t              ctl,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              busErr,
  output logic              errSingle,
  output logic              errMulti,
  output logic              latchBusy,
  output logic [1:0]        diagMode,
  output logic [CHK_W-1:0]  synHeld,
  output logic              irq,
  output logic              nmi
);
  localparam int ADDR_HI_W = ADDR_W - REG_W;
  localparam int FLAG_S    = ADDR_HI_W;
  localparam int FLAG_M    = ADDR_HI_W + 1;

  logic [REG_W-1:0]  diagReg;
  logic              correctEn;
  logic [CHK_W-1:0]  pattern;
  logic [CHK_W-1:0]  genWr;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] flipMask;
  logic              checkHit;
  logic [ADDR_W-1:0] addrHeld;
  logic              flagS;
  logic              flagM;

  assign diagMode  = diagReg[DIAG_MODE_LSB +: 2];
  assign correctEn = diagReg[DIAG_CORR_BIT];
  assign pattern   = diagReg[DIAG_PAT_LSB +: CHK_W];

  // write path
  assign genWr = genCheck(wrData);
  always_comb begin
    unique case (diagMode)
      MODE_SUBST: wrCheck = pattern;
      MODE_FLIP:  wrCheck = genWr ^ pattern;
      default:    wrCheck = genWr;
    endcase
  end

  // read path decode
  assign syndrome = genCheck(rdData) ^ rdCheck;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    assign flipMask[i] = (syndrome == COLS[i]);
  end

  assign checkHit  = $onehot(syndrome);
  assign errSingle = (|flipMask) || checkHit;
  assign errMulti  = (syndrome != '0) && !errSingle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      busErr   <= 1'b0;
    end else begin
      outValid <= rdValid;
      busErr   <= ctl.raiseBus;
      if (rdValid) outData <= correctEn ? (rdData ^ flipMask) : rdData;
    end
  end

  // fault record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      synHeld  <= '0;
      addrHeld <= '0;
      flagS    <= 1'b0;
      flagM    <= 1'b0;
    end else begin
      if (ctl.clrLatch) begin
        synHeld  <= '0;
        addrHeld <= '0;
        flagS    <= 1'b0;
        flagM    <= 1'b0;
      end
      if (ctl.capture) begin
        synHeld  <= syndrome;
        addrHeld <= rdAddr;
        flagS    <= !ctl.capMulti;
        flagM    <= ctl.capMulti;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) diagReg <= DIAG_RESET;
    else if (ctl.wrDiag) diagReg <= regWrData;
  end

  assign latchBusy = flagS || flagM;
  assign irq       = latchBusy;
  assign nmi       = flagM;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_STATUS: begin
        regRdData[ADDR_HI_W-1:0] = addrHeld[ADDR_W-1:REG_W];
        regRdData[FLAG_S]        = flagS;
        regRdData[FLAG_M]        = flagM;
      end
      REG_SYN:    regRdData[CHK_W-1:0] = synHeld;
      REG_ADDRLO: regRdData = addrHeld[REG_W-1:0];
      default:    regRdData = diagReg;
    endcase
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              busErr,
  output logic              irq,
  output logic              nmi,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);
  ctl_t             ctl;
  logic             errSingle;
  logic             errMulti;
  logic             latchBusy;
  logic [1:0]       diagMode;
  logic [CHK_W-1:0] synHeld;

  ecc_control u_ctl (
    .rdValid  (rdValid),
    .errSingle(errSingle),
    .errMulti (errMulti),
    .latchBusy(latchBusy),
    .diagMode (diagMode),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .ctl      (ctl)
  );

  ecc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrData   (wrData),
    .wrCheck  (wrCheck),
    .rdValid  (rdValid),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .rdCheck  (rdCheck),
    .ctl      (ctl),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .outValid (outValid),
    .outData  (outData),
    .busErr   (busErr),
    .errSingle(errSingle),
    .errMulti (errMulti),
    .latchBusy(latchBusy),
    .diagMode (diagMode),
    .synHeld  (synHeld),
    .irq      (irq),
    .nmi      (nmi)
  );
endmodule

// File: rtl/ecc_logger_chk.sv
module ecc_logger_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdValid,
  input logic       errSingle,
  input logic       errMulti,
  input logic [1:0] diagMode,
  input logic [5:0] synHeld,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic       outValid,
  input logic       busErr,
  input logic       irq,
  input logic       nmi
);
  logic clrNow;
  assign clrNow = regWrEn && (regAddr == 2'd0);

  p_clean_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !errSingle && !errMulti |=> !busErr);

  p_bus_beside_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> outValid);

  p_multi_report_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && errMulti && diagMode != 2'd2 && !irq |=> nmi && busErr);

  p_nmi_needs_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    nmi |-> irq);

  p_record_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !clrNow |=> irq && $stable(synHeld));

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrNow && !rdValid |=> !irq);

  p_quiet_mode_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && diagMode == 2'd2 && !irq |=> !irq && !busErr);
endmodule

bind ecc_err_logger ecc_logger_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdValid  (rdValid),
  .errSingle(errSingle),
  .errMulti (errMulti),
  .diagMode (diagMode),
  .synHeld  (synHeld),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .outValid (outValid),
  .busErr   (busErr),
  .irq      (irq),
  .nmi      (nmi)
);

// File: tb/ecc_err_logger_test.sv
`timescale 1ns/1ps
module ecc_err_logger_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] wrData = '0;
  logic [5:0]  wrCheck;
  logic        rdValid = 1'b0;
  logic [19:0] rdAddr = '0;
  logic [15:0] rdData = '0;
  logic [5:0]  rdCheck = '0;
  logic        outValid;
  logic [15:0] outData;
  logic        busErr;
  logic        irq;
  logic        nmi;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  logic [15:0] expDataQ[$];
  logic        expBusQ[$];
  string       tagQ[$];

  logic [5:0] colTab [16] = '{6'h0E, 6'h0B, 6'h07, 6'h0D, 6'h13, 6'h15, 6'h16, 6'h19,
                              6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C};

  always #2.5 clk = ~clk;

  ecc_err_logger uut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrCheck(wrCheck),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData), .rdCheck(rdCheck),
    .outValid(outValid), .outData(outData), .busErr(busErr), .irq(irq), .nmi(nmi),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [5:0] enc(logic [15:0] d);
    logic [5:0] r = '0;
    for (int i = 0; i < 16; i++) if (d[i]) r = r ^ colTab[i];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expDataQ.size() == 0) begin
        check("R2 unexpected outValid", 32'd1, 32'd0);
      end else begin
        logic [15:0] ed;
        logic        eb;
        string       t;
        ed = expDataQ.pop_front();
        eb = expBusQ.pop_front();
        t  = tagQ.pop_front();
        check({t, " data"}, {16'd0, outData}, {16'd0, ed});
        check({t, " busErr"}, {31'd0, busErr}, {31'd0, eb});
      end
    end
  end

  task automatic doRead(logic [19:0] a, logic [15:0] d, logic [5:0] c,
                        logic [15:0] ed, logic eb, string t, bit clr = 0);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a; rdData = d; rdCheck = c;
    if (clr) begin regWrEn = 1'b1; regAddr = 2'd0; regWrData = '0; end
    expDataQ.push_back(ed); expBusQ.push_back(eb); tagQ.push_back(t);
    @(negedge clk);
    rdValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(logic [1:0] a, logic [15:0] e, string t);
    regAddr = a;
    #1;
    check(t, {16'd0, regRdData}, {16'd0, e});
  endtask

  task automatic wrCheckIs(logic [15:0] d, logic [5:0] e, string t);
    @(negedge clk);
    wrData = d;
    #1;
    check(t, {26'd0, wrCheck}, {26'd0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++; nCmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R2 reset outValid", {31'd0, outValid}, 32'd0);
    check("R6 reset irq", {31'd0, irq}, 32'd0);
    check("R6 reset nmi", {31'd0, nmi}, 32'd0);
    regCheck(2'd0, 16'h0000, "R6 reset status");
    regCheck(2'd3, 16'h0004, "R8 reset diag");

    // R1 write code
    wrCheckIs(16'hA5C3, enc(16'hA5C3), "R1 code A5C3");
    wrCheckIs(16'h0000, 6'h00, "R1 code 0000");
    wrCheckIs(16'h0001, 6'h0E, "R1 code bit0");
    wrCheckIs(16'h8000, 6'h2C, "R1 code bit15");
    wrCheckIs(16'hFFFF, enc(16'hFFFF), "R1 code FFFF");

    // R2 clean read
    doRead(20'h12345, 16'h1234, enc(16'h1234), 16'h1234, 1'b0, "R2 clean");
    check("R2 no irq", {31'd0, irq}, 32'd0);

    // R3 data bit 5 flipped
    doRead(20'h12345, 16'h1234 ^ 16'h0020, enc(16'h1234), 16'h1234, 1'b0, "R3 bit5");
    check("R6 irq single", {31'd0, irq}, 32'd1);
    check("R6 nmi single", {31'd0, nmi}, 32'd0);
    regCheck(2'd1, 16'h0015, "R3 syndrome bit5");
    regCheck(2'd2, 16'h2345, "R6 addr low");
    regCheck(2'd0, 16'h0011, "R6 status single+hi");

    // R7 hold
    doRead(20'h0ABCD, 16'h0001, enc(16'h0000), 16'h0000, 1'b0, "R7 second fault corrected");
    regCheck(2'd1, 16'h0015, "R7 syndrome held");
    regCheck(2'd2, 16'h2345, "R7 addr held");
    regWrite(2'd0, 16'h0000);
    check("R7 clear irq", {31'd0, irq}, 32'd0);
    regCheck(2'd0, 16'h0000, "R7 status cleared");

    // R4 check bit 3 flipped
    doRead(20'hF0001, 16'h0F0F, enc(16'h0F0F) ^ 6'h08, 16'h0F0F, 1'b0, "R4 chk3");
    regCheck(2'd1, 16'h0008, "R4 syndrome chk3");
    regCheck(2'd0, 16'h001F, "R4 status");
    regCheck(2'd2, 16'h0001, "R6 addr low chk3");
    regWrite(2'd0, 16'h0000);

    // R3 bits 0 and 1
    doRead(20'h00010, 16'h8001, enc(16'h8000), 16'h8000, 1'b0, "R3 bit0");
    regCheck(2'd1, 16'h000E, "R3 syndrome bit0");
    regWrite(2'd0, 16'h0000);
    doRead(20'h00020, 16'h8002, enc(16'h8000), 16'h8000, 1'b0, "R3 bit1");
    regCheck(2'd1, 16'h000B, "R3 syndrome bit1");
    regWrite(2'd0, 16'h0000);

    // R5 double fault bits 3 and 9
    doRead(20'h30004, 16'h5555 ^ 16'h0208, enc(16'h5555), 16'h5555 ^ 16'h0208, 1'b1, "R5 double");
    check("R5 nmi", {31'd0, nmi}, 32'd1);
    check("R6 irq multi", {31'd0, irq}, 32'd1);
    regCheck(2'd0, 16'h0023, "R5 status multi");
    regCheck(2'd1, 16'h0011, "R5 syndrome");

    // R7 clear and capture in one cycle
    doRead(20'h00007, 16'h4444, enc(16'h4444) ^ 6'h01, 16'h4444, 1'b0, "R7 clear+capture", 1);
    check("R7 irq after clr+cap", {31'd0, irq}, 32'd1);
    check("R7 nmi after clr+cap", {31'd0, nmi}, 32'd0);
    regCheck(2'd1, 16'h0001, "R7 new syndrome");
    regCheck(2'd0, 16'h0010, "R7 new status");
    regWrite(2'd0, 16'h0000);

    // R9 correction off
    regWrite(2'd3, 16'h0000);
    regCheck(2'd3, 16'h0000, "R8 diag readback");
    doRead(20'h00100, 16'h0080, enc(16'h0000), 16'h0080, 1'b0, "R9 raw");
    check("R9 still logs", {31'd0, irq}, 32'd1);
    regCheck(2'd1, 16'h0019, "R9 syndrome");
    regWrite(2'd0, 16'h0000);

    // R10 substitute
    regWrite(2'd3, 16'h2A05);
    regCheck(2'd3, 16'h2A05, "R8 diag pattern readback");
    wrCheckIs(16'h1234, 6'h2A, "R10 substitute");

    // R11 flip
    regWrite(2'd3, 16'h0507);
    wrCheckIs(16'h1234, enc(16'h1234) ^ 6'h05, "R11 flip");

    // R12 quiet
    regWrite(2'd3, 16'h0006);
    doRead(20'h00200, 16'hFF00 ^ 16'h0003, enc(16'hFF00), 16'hFF00 ^ 16'h0003, 1'b0, "R12 quiet double");
    check("R12 no irq", {31'd0, irq}, 32'd0);
    doRead(20'h00201, 16'hFF00 ^ 16'h0400, enc(16'hFF00), 16'hFF00, 1'b0, "R12 quiet single corrected");
    check("R12 no irq single", {31'd0, irq}, 32'd0);
    regCheck(2'd0, 16'h0000, "R12 status empty");

    // back to mode 0
    regWrite(2'd3, 16'h0004);
    doRead(20'h00300, 16'hBEEF, enc(16'hBEEF), 16'hBEEF, 1'b0, "R2 clean after modes");
    wrCheckIs(16'hBEEF, enc(16'hBEEF), "R1 mode 0 again");

    repeat (3) @(negedge clk);
    check("R2 queue drained", expDataQ.size(), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule